// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a three-wire serial sampling converter: it owns an active-low chip select and a serial clock divided down from the system clock, and it reads one data line. Every conversion is one chip-select frame of sixteen serial clock periods. The converter changes its data line on each falling edge of the serial clock, and the controller captures it on the next falling edge. The ten-bit straight-binary result is taken from the middle of the captured word and offered on a valid/ready output. Between frames, chip select is held high for a programmable number of system clocks, which gives the converter its acquisition and quiet time.

A conversion is launched by `start_i` or, back to back, by holding `cont_i`. If `sleep_i` is high when a frame is launched, that frame is cut short after a fixed, parameterised number of serial clock falls. Cutting a frame short in this way is the command that puts the converter into power-down. The converter's first full frame after reset, or after such a power-down frame, only wakes it up. The controller runs that frame but delivers no result from it.

The output holds one result. While `m_valid` is high and `m_ready` is low, `m_data` stays frozen and no new frame is launched. The converter is therefore never sampled into a full slot, and no result is lost. A launch needs the slot to have been empty in the previous cycle.

Top module: `adc_frame_reader`

## Requirements
- R1: Synchronous active-high reset drives `cs_n_o` high, `sclk_o` high, `m_valid` low and `err_o` low.
- R2: A full frame holds `cs_n_o` low for exactly 16×DIV system clocks. Within the frame, `sclk_o` has period DIV, is high for its first DIV/2 clocks after chip select falls, and returns high in the same cycle that chip select rises.
- R3: `sdata_i` is captured at the clock edge where `sclk_o` goes low. Capture k (k = 1..16) becomes word bit 16−k. The result is word bits 12..3, that is, captures 4 to 13, most significant bit first, in straight binary.
- R4: After chip select rises it stays high for at least GAP_CLKS system clocks before it falls again.
- R5: In idle, with the output slot empty, a high `start_i` or `cont_i` pulls chip select low at the next edge. While `cont_i` stays high, frames follow one another separated only by the gap.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays stable, and chip select does not fall.
- R7: A frame launched with `sleep_i` high holds chip select low for SLEEP_FALLS×DIV clocks, which ends it between serial clock fall SLEEP_FALLS and the next fall. It yields no result.
- R8: The first full frame after reset, and the first full frame after a power-down frame, yield no result.
- R9: `err_o` is set when a delivered frame has a one in any of captures 1 to 3 (word bits 15..13). It stays set until reset.
- R10: `sclk_o` is high whenever `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch one conversion |
| cont_i | input | 1 | Launch conversions back to back while high |
| sleep_i | input | 1 | Sampled at launch: abort this frame to request power-down |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sdata_i | input | 1 | Serial data from the converter |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Consumer accepts the result |
| m_data | output | W | Ten-bit straight-binary result |
| err_o | output | 1 | Sticky framing error: a leading bit read as one |

## Verification
The bench builds the block with DIV = 4, GAP_CLKS = 5 and SLEEP_FALLS = 3. With these values a full frame lasts 64 system clocks and a power-down frame lasts 12, so more than ten frames fit in a short run. These frames cover the dummy frame after reset and after power-down, full-scale and zero codes, a corrupted leading bit, and a long consumer stall in continuous mode. The small divider also makes the half-period phase of every serial clock edge visible cycle by cycle, against a behavioural model of frame timing.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock generator: idles high, one period of DIV system clocks,
// high half first. Strobes mark the falling edge and the period end.
module adc_sclk_gen #(
  parameter int DIV = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o,
  output logic fall_o,
  output logic per_end_o
);
  localparam int HALF = DIV / 2;
  localparam int PHW  = $clog2(DIV);
  localparam logic [PHW-1:0] PH_FALL = PHW'(HALF - 1);
  localparam logic [PHW-1:0] PH_END  = PHW'(DIV - 1);

  logic [PHW-1:0] ph;

  assign fall_o    = run && (ph == PH_FALL);
  assign per_end_o = run && (ph == PH_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      sclk_o <= 1'b1;
    end else if (!run) begin
      ph     <= '0;
      sclk_o <= 1'b1;
    end else begin
      if (per_end_o) ph <= '0;
      else           ph <= ph + 1'b1;
      if (fall_o)         sclk_o <= 1'b0;
      else if (per_end_o) sclk_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_in.sv
// Capture register: shifts one bit in per strobe, exposes the top KEEP bits.
module adc_shift_in #(
  parameter int BITS = 16,
  parameter int KEEP = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [KEEP-1:0] head_o
);
  logic [BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[BITS-2:0], din};
  end

  assign head_o = sr[BITS-1 -: KEEP];
endmodule

// File: rtl/adc_result_slot.sv
// One-entry output stage with valid/ready handshake.
module adc_result_slot #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load) begin
      valid_o <= 1'b1;
      data_o  <= load_data;
    end else if (valid_o && ready) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV         = 14,
  parameter int GAP_CLKS    = 88,
  parameter int SLEEP_FALLS = 4,
  parameter int FRAME_BITS  = 16,
  parameter int LEAD_BITS   = 3,
  parameter int W           = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         cont_i,
  input  logic         sleep_i,
  output logic         cs_n_o,
  output logic         sclk_o,
  input  logic         sdata_i,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         err_o
);
  localparam int KEEP = LEAD_BITS + W;
  localparam int PW   = $clog2(FRAME_BITS);
  localparam int GW   = $clog2(GAP_CLKS + 1);
  localparam logic [PW-1:0] LAST_FULL  = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] LAST_SLEEP = PW'(SLEEP_FALLS - 1);
  localparam logic [GW-1:0] GAP_LAST   = GW'(GAP_CLKS - 1);

  if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
    $error("DIV must be even and at least 2");
  end
  if (SLEEP_FALLS < 2 || SLEEP_FALLS > 9) begin : g_bad_sleep
    $error("SLEEP_FALLS must lie in 2..9");
  end
  if (GAP_CLKS < 1) begin : g_bad_gap
    $error("GAP_CLKS must be at least 1");
  end

  rd_state_e       st;
  logic [PW-1:0]   per;
  logic [GW-1:0]   gcnt;
  logic            abort_q;
  logic            dummy_q;
  logic            fall, per_end;
  logic [KEEP-1:0] head;
  logic            last, frame_done, launch, deliver;

  adc_sclk_gen #(.DIV(DIV)) u_sclk (
    .clk(clk), .rst(rst), .run(st == ST_FRAME),
    .sclk_o(sclk_o), .fall_o(fall), .per_end_o(per_end)
  );

  adc_shift_in #(.BITS(FRAME_BITS), .KEEP(KEEP)) u_shift (
    .clk(clk), .rst(rst), .shift_en(fall), .din(sdata_i), .head_o(head)
  );

  assign last       = abort_q ? (per == LAST_SLEEP) : (per == LAST_FULL);
  assign frame_done = per_end && last;
  assign launch     = (st == ST_IDLE) && (start_i || cont_i) && !m_valid;
  assign deliver    = frame_done && !abort_q && !dummy_q;

  adc_result_slot #(.W(W)) u_slot (
    .clk(clk), .rst(rst), .load(deliver), .load_data(head[W-1:0]),
    .ready(m_ready), .valid_o(m_valid), .data_o(m_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      per     <= '0;
      gcnt    <= '0;
      abort_q <= 1'b0;
      dummy_q <= 1'b1;
      cs_n_o  <= 1'b1;
      err_o   <= 1'b0;
    end else begin
      if (deliver && (|head[KEEP-1:W])) err_o <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (launch) begin
            st      <= ST_FRAME;
            per     <= '0;
            abort_q <= sleep_i;
            cs_n_o  <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (frame_done) begin
            st     <= ST_GAP;
            gcnt   <= '0;
            cs_n_o <= 1'b1;
            if (abort_q) dummy_q <= 1'b1;
            else         dummy_q <= 1'b0;
          end else if (per_end) begin
            per <= per + 1'b1;
          end
        end
        ST_GAP: begin
          if (gcnt == GAP_LAST) st   <= ST_IDLE;
          else                  gcnt <= gcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n_o,
  input logic         sclk_o,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_data,
  input logic         err_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (cs_n_o && sclk_o && !m_valid && !err_o));

  a_r10_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  a_r2_sclk_quiet_outside_frame: assert property (@(posedge clk) disable iff (rst)
    (cs_n_o && $past(cs_n_o)) |-> $stable(sclk_o));

  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r6_no_launch_when_full: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> !$past(m_valid));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .err_o(err_o)
);

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;
  localparam int DIV_T = 4;
  localparam int GAP_T = 5;
  localparam int SLP_T = 3;
  localparam int HALF_T = DIV_T / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, cont_i = 1'b0, sleep_i = 1'b0, m_ready = 1'b1;
  logic sdata = 1'b0;
  logic cs_n_o, sclk_o, m_valid, err_o;
  logic [9:0] m_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_frame_reader #(.DIV(DIV_T), .GAP_CLKS(GAP_T), .SLEEP_FALLS(SLP_T)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i), .sleep_i(sleep_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdata_i(sdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Converter word for frame f: {lead[2:0], data[9:0], 3'b000}
  function automatic logic [15:0] make_word(input int f);
    logic [9:0] d;
    logic [2:0] ld;
    d  = 10'((f * 37 + 5) % 1024);
    if (f == 2) d = 10'h3FF;
    if (f == 3) d = 10'h000;
    ld = (f == 4) ? 3'b010 : 3'b000;
    return {ld, d, 3'b000};
  endfunction

  // ---------------- behavioural reference model (posedge) ----------------
  int   m_state = 0, m_t = 0, m_g = 0;
  bit   m_abort = 0, m_dummy = 1;
  bit   e_cs = 1, e_sclk = 1, e_valid = 0, e_err = 0;
  logic [9:0]  e_data = '0;
  logic [15:0] cur_word = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; e_cs = 1; e_sclk = 1; e_valid = 0; e_err = 0; m_dummy = 1;
    end else begin
      bit v_old;
      int len;
      v_old = e_valid;
      if (v_old && m_ready) e_valid = 0;
      case (m_state)
        0: if ((start_i || cont_i) && !v_old) begin
             m_state = 1; m_t = 0; m_abort = sleep_i; e_cs = 0; e_sclk = 1;
           end
        1: begin
             m_t++;
             len = (m_abort ? SLP_T : 16) * DIV_T;
             if (m_t == len) begin
               e_cs = 1; e_sclk = 1; m_state = 2; m_g = 0;
               if (m_abort) m_dummy = 1;
               else if (m_dummy) m_dummy = 0;
               else begin
                 e_valid = 1;
                 e_data  = cur_word[12:3];
                 if (cur_word[15:13] != 0) e_err = 1;
               end
             end else begin
               e_sclk = ((m_t % DIV_T) < HALF_T);
             end
           end
        default: if (m_g == GAP_T - 1) m_state = 0; else m_g++;
      endcase
    end
  end

  // -------------- compare, converter model, measurements (negedge) --------------
  bit prev_cs = 1, prev_sclk = 1;
  int fidx = 0, bidx = 0, nfalls = 0, nvalid = 0;
  int lowcnt = 0, last_low = 0, highcnt = 0, min_high = 1000000;
  bit seen_max = 0, seen_zero = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(cs_n_o == e_cs,   "R2 cs_n_o",  cs_n_o, e_cs);
      chk(sclk_o == e_sclk, "R10 sclk_o", sclk_o, e_sclk);
      chk(m_valid == e_valid, "R6 m_valid", m_valid, e_valid);
      chk(err_o == e_err,   "R9 err_o",   err_o, e_err);
      if (e_valid) chk(m_data == e_data, "R3 m_data", m_data, e_data);
      if (m_valid && m_ready) begin
        nvalid++;
        if (m_data == 10'h3FF) seen_max = 1;
        if (m_data == 10'h000) seen_zero = 1;
      end
      if (!cs_n_o) lowcnt++;
      else highcnt++;
      if (!prev_cs && cs_n_o) begin last_low = lowcnt; lowcnt = 0; highcnt = 1; end
      if (prev_cs && !cs_n_o && nfalls > 0 && highcnt < min_high) min_high = highcnt;
    end
    if (prev_cs && !cs_n_o) begin
      cur_word = make_word(fidx);
      fidx++; nfalls++; bidx = 0;
      sdata = cur_word[15];
    end else if (!cs_n_o && prev_sclk && !sclk_o) begin
      bidx++;
      sdata = (bidx < 16) ? cur_word[15 - bidx] : 1'b0;
    end
    prev_cs = cs_n_o;
    prev_sclk = sclk_o;
  end

  task automatic launch_one(input bit slp);
    sleep_i = slp; start_i = 1;
    while (cs_n_o) @(negedge clk);
    start_i = 0; sleep_i = 0;
  endtask

  task automatic wait_done();
    while (cs_n_o) @(negedge clk);
    while (!cs_n_o) @(negedge clk);
    repeat (GAP_T + 3) @(negedge clk);
  endtask

  task automatic wait_falls(input int n);
    while (nfalls < n) @(negedge clk);
  endtask

  initial begin
    int nf;
    repeat (4) @(negedge clk);
    chk(cs_n_o && sclk_o && !m_valid && !err_o, "R1 reset state", {cs_n_o, sclk_o, m_valid, err_o}, 4'b1100);
    rst = 0;
    @(negedge clk);
    chk(cs_n_o && sclk_o, "R1 idle after reset", {cs_n_o, sclk_o}, 2'b11);

    launch_one(0); wait_done();
    chk(nvalid == 0, "R8 dummy after reset", nvalid, 0);
    launch_one(0); wait_done();
    chk(nvalid == 1, "R5 start launches one", nvalid, 1);
    chk(last_low == 16 * DIV_T, "R2 frame length", last_low, 16 * DIV_T);

    cont_i = 1;
    wait_falls(4);
    m_ready = 0;
    repeat (250) @(negedge clk);
    nf = nfalls;
    repeat (100) @(negedge clk);
    chk(nfalls == nf, "R6 no launch while stalled", nfalls, nf);
    chk(m_valid == 1, "R6 result held", m_valid, 1);
    m_ready = 1;
    wait_falls(7);
    cont_i = 0;
    wait_done();
    chk(nvalid == 6, "R5 continuous frames", nvalid, 6);
    chk(err_o == 1, "R9 leading bit error", err_o, 1);
    chk(seen_max && seen_zero, "R3 full-scale and zero codes", {seen_max, seen_zero}, 2'b11);
    chk(min_high >= GAP_T, "R4 minimum gap", min_high, GAP_T);

    launch_one(1); wait_done();
    chk(last_low == SLP_T * DIV_T, "R7 power-down frame length", last_low, SLP_T * DIV_T);
    chk(nvalid == 6, "R7 no result from power-down", nvalid, 6);
    launch_one(0); wait_done();
    chk(nvalid == 6, "R8 dummy after wake", nvalid, 6);
    launch_one(0); wait_done();
    chk(nvalid == 7, "R5 valid after wake", nvalid, 7);
    chk(err_o == 1, "R9 error stays set", err_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule